// File: doc/BRIEF.md
# Composite Video Raster Legality Checker

The block watches a pixel-clocked raster: a one-clock line-start strobe, horizontal sync, vertical sync and an active-pixel flag. It measures each line and each field, then decides whether the raster can be accepted by a standard-definition composite video encoder. Two line families exist. A 858-clock line belongs to the 525-line family and a 864-clock line belongs to the 625-line family. The vertical limits that apply to a field depend on which family its lines belong to.

A field starts at the first line whose line-start strobe sees vertical sync high after a line that had it low. The measurement of a field closes at the next such line. At that point the block updates a mode-valid flag and the family output. It also merges the rules that failed into a set of sticky error flags, which an external clear input empties. Every counter stops at its all-ones value and does not wrap. An overlong line or field therefore always fails a rule. All widths, totals and limits are parameters; the defaults carry the broadcast values.

Top module: `tv_raster_checker`

## Requirements
- R1: After reset `mode_ok`, `fam_625` and `err_flags` are all zero.
- R2: A line must last exactly `H525` (858) or `H625` (864) clocks. The first legal line of a field fixes the family, and `fam_625` reports 1 for the 864-clock family. Any other length, or a line of the other family later in the same field, sets `err_flags[0]`.
- R3: A line with active pixels whose active count is not a multiple of 4 sets `err_flags[1]`.
- R4: A line in which horizontal sync is never high sets `err_flags[2]`.
- R5: A field longer than 262 lines (525 family) or 312 lines (625 family) sets `err_flags[3]`. Exactly the cap is legal.
- R6: A field whose count of active lines is outside 1..253 (525 family) or 1..305 (625 family) sets `err_flags[4]`.
- R7: A field with no blank line between its last active line and the next vertical sync sets `err_flags[5]`. This includes a field with no active line at all.
- R8: A vertical sync run that is not exactly 3 lines sets `err_flags[6]`.
- R9: Fewer than 4 (525 family) or 2 (625 family) blank lines between the end of vertical sync and the first active line set `err_flags[7]`.
- R10: `mode_ok` stays 0 until one whole field has been measured. From then on it, and `fam_625`, change only at a field start. At each field start `mode_ok` becomes 1 exactly when the field that just closed broke no rule.
- R11: Error flags are sticky and are set only at a field start. `err_clr` empties them one cycle later. A flag raised at the same field start still appears.
- R12: Line and field counters saturate. A line longer than the pixel counter range still reports `err_flags[0]`, and a field longer than the line counter range still reports `err_flags[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | High on the first clock of each line |
| hsync_in | input | 1 | Horizontal sync level |
| vsync_in | input | 1 | Vertical sync level, sampled at line start |
| pix_act | input | 1 | Active-pixel flag |
| err_clr | input | 1 | Clears all sticky error flags |
| mode_ok | output | 1 | Last measured field was legal |
| fam_625 | output | 1 | Family of the last measured field (1 = 864-clock) |
| err_flags | output | 8 | Sticky rule failures, bit order as in R2..R9 |

## Verification
The assertions assume that vertical sync matters only at line-start clocks, and that every field opens with a sync line. The stimulus satisfies both: it changes vertical sync only together with the line-start strobe and always begins each field with its sync lines. The bench instantiates the block with scaled-down line lengths, field caps and counter widths. This keeps fields short and lets both saturation cases be reached in a few thousand clocks. The expected results are computed from those same parameter values.

// File: rtl/tv_raster_checker.sv
module tv_raster_checker #(
  parameter int H525     = 858,
  parameter int H625     = 864,
  parameter int V525_MAX = 262,
  parameter int V625_MAX = 312,
  parameter int A525_MAX = 253,
  parameter int A625_MAX = 305,
  parameter int B525_MIN = 4,
  parameter int B625_MIN = 2,
  parameter int VS_LINES = 3,
  parameter int HW       = 11,
  parameter int LW       = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic       hsync_in,
  input  logic       vsync_in,
  input  logic       pix_act,
  input  logic       err_clr,
  output logic       mode_ok,
  output logic       fam_625,
  output logic [7:0] err_flags
);
  localparam logic [HW-1:0] HT_A = HW'(H525);
  localparam logic [HW-1:0] HT_B = HW'(H625);
  localparam logic [LW-1:0] VM_A = LW'(V525_MAX);
  localparam logic [LW-1:0] VM_B = LW'(V625_MAX);
  localparam logic [LW-1:0] AM_A = LW'(A525_MAX);
  localparam logic [LW-1:0] AM_B = LW'(A625_MAX);
  localparam logic [LW-1:0] BM_A = LW'(B525_MIN);
  localparam logic [LW-1:0] BM_B = LW'(B625_MIN);
  localparam logic [LW-1:0] VS_N = LW'(VS_LINES);

  function automatic logic [HW-1:0] hinc(input logic [HW-1:0] v);
    return (&v) ? v : v + HW'(1);
  endfunction

  function automatic logic [LW-1:0] linc(input logic [LW-1:0] v);
    return (&v) ? v : v + LW'(1);
  endfunction

  logic [HW-1:0] pix_cnt, act_cnt, hs_cnt;
  logic          line_open, line_vs, started;
  logic [LW-1:0] f_tot, f_sync, f_back, f_act, f_front;
  logic          f_seen, f_famset, f_pal;
  logic [2:0]    f_herr;

  logic [LW-1:0] u_tot, u_sync, u_back, u_act, u_front;
  logic          u_seen, u_famset, u_pal;
  logic [2:0]    u_herr;
  logic [7:0]    new_err;

  wire ln_end = line_start && line_open;
  wire l_ok   = (pix_cnt == HT_A) || (pix_cnt == HT_B);
  wire l_pal  = (pix_cnt == HT_B);
  wire ln_de  = (act_cnt != '0);
  wire fb     = line_start && vsync_in && !line_vs;
  wire eval   = fb && started;

  wire [2:0] ln_herr = ln_end ? {hs_cnt == '0,
                                 ln_de && (act_cnt[1:0] != 2'b00),
                                 !l_ok || (f_famset && (l_pal != f_pal))} : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_cnt   <= '0;
      act_cnt   <= '0;
      hs_cnt    <= '0;
      line_open <= 1'b0;
      line_vs   <= 1'b0;
    end else if (line_start) begin
      pix_cnt   <= HW'(1);
      act_cnt   <= {{(HW-1){1'b0}}, pix_act};
      hs_cnt    <= {{(HW-1){1'b0}}, hsync_in};
      line_open <= 1'b1;
      line_vs   <= vsync_in;
    end else begin
      pix_cnt <= hinc(pix_cnt);
      if (pix_act)  act_cnt <= hinc(act_cnt);
      if (hsync_in) hs_cnt  <= hinc(hs_cnt);
    end
  end

  always_comb begin
    u_tot    = f_tot;
    u_sync   = f_sync;
    u_back   = f_back;
    u_act    = f_act;
    u_front  = f_front;
    u_seen   = f_seen;
    u_famset = f_famset;
    u_pal    = f_pal;
    u_herr   = f_herr | ln_herr;
    if (ln_end) begin
      u_tot = linc(f_tot);
      if (line_vs) begin
        u_sync = linc(f_sync);
      end else if (ln_de) begin
        u_act   = linc(f_act);
        u_seen  = 1'b1;
        u_front = '0;
      end else if (!f_seen) begin
        u_back = linc(f_back);
      end else begin
        u_front = linc(f_front);
      end
      if (!f_famset && l_ok) begin
        u_famset = 1'b1;
        u_pal    = l_pal;
      end
    end
  end

  wire [LW-1:0] vmax = u_pal ? VM_B : VM_A;
  wire [LW-1:0] amax = u_pal ? AM_B : AM_A;
  wire [LW-1:0] bmin = u_pal ? BM_B : BM_A;

  assign new_err = {u_back < bmin,
                    u_sync != VS_N,
                    u_front == '0,
                    (u_act == '0) || (u_act > amax),
                    u_tot > vmax,
                    u_herr};

  always_ff @(posedge clk) begin
    if (!rst_n || fb) begin
      f_tot    <= '0;
      f_sync   <= '0;
      f_back   <= '0;
      f_act    <= '0;
      f_front  <= '0;
      f_seen   <= 1'b0;
      f_famset <= 1'b0;
      f_pal    <= 1'b0;
      f_herr   <= '0;
    end else if (ln_end) begin
      f_tot    <= u_tot;
      f_sync   <= u_sync;
      f_back   <= u_back;
      f_act    <= u_act;
      f_front  <= u_front;
      f_seen   <= u_seen;
      f_famset <= u_famset;
      f_pal    <= u_pal;
      f_herr   <= u_herr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started   <= 1'b0;
      mode_ok   <= 1'b0;
      fam_625   <= 1'b0;
      err_flags <= '0;
    end else begin
      if (fb) started <= 1'b1;
      if (eval) begin
        mode_ok   <= (new_err == '0);
        fam_625   <= u_pal;
        err_flags <= (err_clr ? 8'h00 : err_flags) | new_err;
      end else if (err_clr) begin
        err_flags <= '0;
      end
    end
  end

  AST_OK_LOW_UNTIL_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !mode_ok); // R10
  AST_OK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> ($stable(mode_ok) && $stable(fam_625))); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags))); // R11
  AST_ERR_ONLY_AT_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> ((err_flags & ~$past(err_flags)) == 8'h00)); // R11
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !eval) |=> (err_flags == 8'h00)); // R11
  AST_PIX_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((&pix_cnt) && !line_start) |=> (&pix_cnt)); // R12
  AST_LINE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((&f_tot) && !fb) |=> (&f_tot)); // R12
endmodule

// File: tb/tv_raster_checker_tb_top.sv
`timescale 1ns/1ps
module tv_raster_checker_tb_top;
  localparam int HA = 58, HB = 64, VMA = 22, VMB = 30, AMA = 13, AMB = 21;
  localparam int BMA = 4, BMB = 2, VSN = 3, HWB = 7, LWB = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_start = 0, hsync_in = 0, vsync_in = 0, pix_act = 0, err_clr = 0;
  logic mode_ok, fam_625;
  logic [7:0] err_flags;

  int checks = 0, errors = 0;
  bit eval_due = 0, eval_seen = 0, done = 0;
  bit q_ok[$], q_pal[$];
  logic [7:0] q_err[$];
  string q_tag[$];
  logic [7:0] acc = 8'h00;

  always #4 clk = ~clk;

  tv_raster_checker #(.H525(HA), .H625(HB), .V525_MAX(VMA), .V625_MAX(VMB),
    .A525_MAX(AMA), .A625_MAX(AMB), .B525_MIN(BMA), .B625_MIN(BMB),
    .VS_LINES(VSN), .HW(HWB), .LW(LWB)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .hsync_in(hsync_in),
    .vsync_in(vsync_in), .pix_act(pix_act), .err_clr(err_clr),
    .mode_ok(mode_ok), .fam_625(fam_625), .err_flags(err_flags));

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) eval_seen <= eval_due;

  always @(negedge clk) begin
    if (eval_seen && q_ok.size() != 0) begin
      bit eo, ep;
      logic [7:0] ee;
      string t;
      eo = q_ok.pop_front(); ep = q_pal.pop_front();
      ee = q_err.pop_front(); t = q_tag.pop_front();
      chk(mode_ok == eo, {t, " mode_ok"}, mode_ok, eo);
      chk(fam_625 == ep, {t, " fam_625"}, fam_625, ep);
      chk(err_flags == ee, {t, " err_flags"}, err_flags, ee);
    end
  end

  task automatic drive_line(input int ht, input int ha, input int hsw, input bit act,
                            input bit vsl, input bit first, input bit clr_here);
    for (int c = 0; c < ht; c++) begin
      @(posedge clk); #2;
      line_start = (c == 0);
      hsync_in   = (c < hsw);
      pix_act    = act && (c >= hsw + 4) && (c < hsw + 4 + ha);
      vsync_in   = vsl;
      eval_due   = first && (c == 0) && (q_ok.size() != 0);
      err_clr    = clr_here && (c == 5);
      if (clr_here && c == 7) chk(err_flags == 8'h00, "R11 clear", err_flags, 0);
    end
  endtask

  task automatic run_field(input int ht, input int ha, input int hsw, input int ns,
                           input int nb, input int na, input int nf, input int odd,
                           input bit do_clr, input string tag);
    int n, tot, fe, be;
    bit pal;
    logic [7:0] e;
    n = ns + nb + na + nf;
    for (int l = 0; l < n; l++)
      drive_line((odd != 0 && l == n - 1) ? odd : ht, ha, hsw,
                 (l >= ns + nb) && (l < ns + nb + na), l < ns, l == 0,
                 do_clr && (l == n - 1));
    pal = (ht == HB);
    tot = (n > (1 << LWB) - 1) ? (1 << LWB) - 1 : n;
    fe  = (na == 0) ? 0 : nf;
    be  = (na == 0) ? nb + nf : nb;
    e = 8'h00;
    e[0] = !(ht == HA || ht == HB) || (odd != 0 && odd != ht);
    e[1] = (na > 0) && (ha % 4 != 0);
    e[2] = (hsw == 0);
    e[3] = tot > (pal ? VMB : VMA);
    e[4] = (na < 1) || (na > (pal ? AMB : AMA));
    e[5] = (fe == 0);
    e[6] = (ns != VSN);
    e[7] = be < (pal ? BMB : BMA);
    if (do_clr) acc = 8'h00;
    acc |= e;
    q_ok.push_back(e == 8'h00);
    q_pal.push_back(pal);
    q_err.push_back(acc);
    q_tag.push_back(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(mode_ok == 0 && fam_625 == 0 && err_flags == 0, "R1 reset",
        {mode_ok, fam_625, err_flags}, 0);
    run_field(HA, 40, 4, 3, 4, 5, 1, 0, 0, "R2 525 legal");
    chk(mode_ok == 0, "R10 low before first field", mode_ok, 0);
    run_field(HB, 40, 4, 3, 2, 5, 1, 0, 0, "R9 625 minimum back");
    run_field(HA, 40, 4, 3, 3, 5, 1, 0, 0, "R9 525 short back");
    run_field(HA, 40, 4, 2, 4, 5, 1, 0, 1, "R8 short sync");
    run_field(HA, 40, 4, 4, 4, 5, 1, 0, 1, "R8 long sync");
    run_field(HA, 40, 4, 3, 4, 5, 0, 0, 1, "R7 no front");
    run_field(HA, 40, 4, 3, 4, 0, 3, 0, 1, "R6 no active");
    run_field(HA, 40, 4, 3, 4, 14, 1, 0, 1, "R6 active over");
    run_field(HA, 40, 4, 3, 4, 13, 3, 0, 1, "R5 total over");
    run_field(HB, 40, 4, 3, 2, 21, 4, 0, 1, "R5 625 at caps");
    run_field(HB, 40, 4, 3, 1, 5, 1, 0, 1, "R9 625 short back");
    run_field(60, 40, 4, 3, 4, 5, 1, 0, 1, "R2 bad total");
    run_field(HA, 40, 4, 3, 4, 5, 2, HB, 1, "R2 mixed family");
    run_field(HA, 30, 4, 3, 4, 5, 1, 0, 1, "R3 width");
    run_field(HA, 40, 0, 3, 4, 5, 1, 0, 1, "R4 no hsync");
    run_field(HA, 40, 4, 3, 4, 5, 58, 0, 1, "R12 field saturate");
    run_field(HA, 40, 4, 3, 4, 5, 2, 200, 1, "R12 line saturate");
    run_field(HB, 40, 4, 3, 2, 5, 1, 0, 0, "R11 sticky");
    run_field(HA, 40, 4, 3, 4, 5, 1, 0, 1, "R10 recover");
    drive_line(HA, 40, 4, 1'b0, 1'b1, 1'b1, 1'b0);
    repeat (4) @(posedge clk);
    chk(q_ok.size() == 0, "R10 all fields evaluated", q_ok.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule